// File: doc/BRIEF.md
# Nested vectored priority interrupt engine

The engine picks which interrupt a processor should service next and remembers which one was interrupted. Sixteen programmable slots each carry a 32-bit handler address and a control byte that ties the slot to one of 32 request lines. Slot number sets priority: slot 0 wins over slot 1, and so on down to slot 15. A request line that no enabled slot claims is served at an extra level 16, which uses a shared default handler address.

From the slot controls the engine derives, for every service level, the set of request lines that outrank that level. The interrupt output is raised when a gated request falls inside that set for the level now being serviced. Software acknowledges by reading the acknowledge word. The read moves the service level up to the best raw request above the current level, stores the level it left, and returns that level's handler address. Writing the acknowledge word ends the handler and returns to the stored level, so nested interrupts unwind in last-in, first-out order.

Register accesses use a single-cycle request strobe. Each strobe cycle is exactly one access, so a bus that holds an access through wait states sends the strobe once only. Read data appears on the cycle after the strobe.

Top module: `nest_vic`

## Requirements
- R1: After reset every slot address, slot control byte and the default address read as zero. The service level is idle, so any gated request raises `irq_o`.
- R2: In a slot control byte, bit 5 enables the slot and bits 4:0 give the request line it serves. A slot with bit 5 clear claims no line, and its line is served at level 16 with the default address.
- R3: `irq_o` is high exactly when `pend_i` shares a bit with the outranking set of the current level. For level L (0..15) that set holds the lines of the enabled slots numbered below L. For level 16 it holds the lines of all enabled slots. When idle it holds all 32 lines. The acknowledge logic looks only at `raw_i`, never at `pend_i`.
- R4: A read of byte 0x30 finds the lowest-numbered enabled slot below the current level whose line is raw-pending. The service level becomes that slot, and the read returns the slot's address.
- R5: If the read of 0x30 finds raw requests that no higher enabled slot claims, and the engine is idle, the level becomes 16 and the default address is returned. With no raw request while idle, the default address is returned and the level stays idle.
- R6: A read of 0x30 that finds nothing above the current level leaves the level unchanged and returns the current level's address.
- R7: A write to 0x30 returns to the level saved when the current level was entered. The written data is ignored, and the write has no effect while idle.
- R8: Acknowledges nest through all levels, and writes unwind them in reverse order. The level never exceeds idle.
- R9: Slot k's address sits at byte 0x100+4k and its control byte at 0x200+4k (low 8 bits). The default address sits at 0x34. All of them read back, and read data is valid the cycle after the strobe.
- R10: A change to a control byte reaches `irq_o` one cycle after the register write takes effect, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| raw_i | input | 32 | Raw request word, used by acknowledge |
| pend_i | input | 32 | Gated request word, used for `irq_o` |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions check, on every cycle, that the level stays within range and moves only on an access to the acknowledge word. They also check that an acknowledge never lowers priority, that a return always drops to a lower-priority level, that idle passes every request to `irq_o`, and that level 0 masks everything. The bench's scenarios are the only way to show which slot an acknowledge picks, the addresses returned, the exact unwind order, the one-cycle lag of a control change, and the split between raw and gated requests.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VIC_NSRC  = 32;
  localparam int unsigned VIC_NSLOT = 16;
  localparam int unsigned VIC_DW    = 32;
  localparam int unsigned VIC_ABW   = 12;
  localparam int unsigned VIC_CW    = 8;

  localparam int unsigned OFS_ACK       = 'h030;
  localparam int unsigned OFS_DEF       = 'h034;
  localparam int unsigned OFS_SLOT_ADDR = 'h100;
  localparam int unsigned OFS_SLOT_CTRL = 'h200;
endpackage

// File: rtl/vic_slot_regs.sv
module vic_slot_regs #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 8,
  localparam int unsigned IW   = $clog2(NSLOT)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       addr_we_i,
  input  logic                       ctrl_we_i,
  input  logic                       def_we_i,
  input  logic [IW-1:0]              idx_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NSLOT-1:0][DW-1:0]   slot_addr_o,
  output logic [NSLOT-1:0][CW-1:0]   slot_ctrl_o,
  output logic [DW-1:0]              def_addr_o
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_addr_o[k] <= '0;
        slot_ctrl_o[k] <= '0;
      end else if (idx_i == IW'(k)) begin
        if (addr_we_i) slot_addr_o[k] <= wdata_i;
        if (ctrl_we_i) slot_ctrl_o[k] <= wdata_i[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       def_addr_o <= '0;
    else if (def_we_i) def_addr_o <= wdata_i;
  end
endmodule

// File: rtl/vic_prec_mask.sv
module vic_prec_mask #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned NSRC  = 32,
  parameter int unsigned CW    = 8,
  localparam int unsigned SW   = $clog2(NSRC)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NSLOT-1:0][CW-1:0]      slot_ctrl_i,
  output logic [NSLOT:0][NSRC-1:0]      mask_o
);
  logic [NSLOT:0][NSRC-1:0] pre;
  logic [NSRC-1:0]          acc;

  // mask for level L = lines of enabled slots numbered below L
  always_comb begin
    acc = '0;
    for (int k = 0; k < NSLOT; k++) begin
      pre[k] = acc;
      if (slot_ctrl_i[k][SW]) acc[slot_ctrl_i[k][SW-1:0]] = 1'b1;
    end
    pre[NSLOT] = acc;
  end

  for (genvar l = 0; l <= NSLOT; l++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_o[l] <= '0;
      else         mask_o[l] <= pre[l];
    end
  end
endmodule

// File: rtl/vic_level_ctl.sv
module vic_level_ctl #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned NSRC  = 32,
  localparam int unsigned LW   = $clog2(NSLOT + 2),
  localparam int unsigned IDLE = NSLOT + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NSLOT:0][NSRC-1:0]   mask_i,
  input  logic [NSRC-1:0]            raw_i,
  input  logic                       ack_rd_i,
  input  logic                       ack_wr_i,
  output logic [LW-1:0]              lvl_o,
  output logic [LW-1:0]              next_lvl_o,
  output logic [NSRC-1:0]            cur_mask_o
);
  logic [LW-1:0]          lvl_q;
  logic [LW-1:0]          scan_lvl;
  logic [NSLOT:0]         hit;
  logic [NSLOT:0][LW-1:0] save_q;

  // level i is taken if a raw line outranks level i+1 and i is above current
  for (genvar i = 0; i <= NSLOT; i++) begin : g_hit
    if (i < NSLOT) begin : g_slot
      assign hit[i] = (|(raw_i & mask_i[i+1])) && (LW'(i) < lvl_q);
    end else begin : g_def
      assign hit[i] = (|raw_i) && (LW'(i) < lvl_q);
    end
  end

  always_comb begin
    scan_lvl = lvl_q;
    for (int i = NSLOT; i >= 0; i--) begin
      if (hit[i]) scan_lvl = LW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LW'(IDLE);
      for (int i = 0; i <= NSLOT; i++) save_q[i] <= LW'(IDLE);
    end else if (ack_rd_i && (scan_lvl != lvl_q)) begin
      save_q[scan_lvl] <= lvl_q;
      lvl_q            <= scan_lvl;
    end else if (ack_wr_i && (lvl_q != LW'(IDLE))) begin
      lvl_q <= save_q[lvl_q];
    end
  end

  assign cur_mask_o = (lvl_q >= LW'(IDLE)) ? '1 : mask_i[lvl_q];
  assign lvl_o      = lvl_q;
  assign next_lvl_o = scan_lvl;
endmodule

// File: rtl/nest_vic.sv
module nest_vic
  import vic_pkg::*;
#(
  parameter int unsigned NSRC  = VIC_NSRC,
  parameter int unsigned NSLOT = VIC_NSLOT,
  parameter int unsigned DW    = VIC_DW,
  parameter int unsigned ABW   = VIC_ABW,
  parameter int unsigned CW    = VIC_CW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [ABW-1:0]  addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] pend_i,
  output logic            irq_o
);
  localparam int unsigned IW = $clog2(NSLOT);
  localparam int unsigned LW = $clog2(NSLOT + 2);

  logic [31:0]              a32;
  logic                     in_saddr, in_sctrl, is_def, is_ack;
  logic [IW-1:0]            idx;
  logic                     ack_rd, ack_wr;
  logic [NSLOT-1:0][DW-1:0] slot_addr;
  logic [NSLOT-1:0][CW-1:0] slot_ctrl;
  logic [DW-1:0]            def_addr;
  logic [NSLOT:0][NSRC-1:0] mask;
  logic [LW-1:0]            lvl_q, next_lvl;
  logic [NSRC-1:0]          cur_mask;
  logic [DW-1:0]            ack_addr, rd_mux, rdata_q;

  assign a32      = 32'(addr_i);
  assign in_saddr = (a32 >= OFS_SLOT_ADDR) && (a32 < OFS_SLOT_ADDR + 4 * NSLOT);
  assign in_sctrl = (a32 >= OFS_SLOT_CTRL) && (a32 < OFS_SLOT_CTRL + 4 * NSLOT);
  assign is_def   = (a32 == OFS_DEF);
  assign is_ack   = (a32 == OFS_ACK);
  assign idx      = addr_i[IW+1:2];
  assign ack_rd   = req_i && !we_i && is_ack;
  assign ack_wr   = req_i &&  we_i && is_ack;

  vic_slot_regs #(.NSLOT(NSLOT), .DW(DW), .CW(CW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_we_i   (req_i && we_i && in_saddr),
    .ctrl_we_i   (req_i && we_i && in_sctrl),
    .def_we_i    (req_i && we_i && is_def),
    .idx_i       (idx),
    .wdata_i     (wdata_i),
    .slot_addr_o (slot_addr),
    .slot_ctrl_o (slot_ctrl),
    .def_addr_o  (def_addr)
  );

  vic_prec_mask #(.NSLOT(NSLOT), .NSRC(NSRC), .CW(CW)) u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_ctrl_i (slot_ctrl),
    .mask_o      (mask)
  );

  vic_level_ctl #(.NSLOT(NSLOT), .NSRC(NSRC)) u_lvl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_i     (mask),
    .raw_i      (raw_i),
    .ack_rd_i   (ack_rd),
    .ack_wr_i   (ack_wr),
    .lvl_o      (lvl_q),
    .next_lvl_o (next_lvl),
    .cur_mask_o (cur_mask)
  );

  // level 16 and idle both hand out the default address
  assign ack_addr = (next_lvl >= LW'(NSLOT)) ? def_addr : slot_addr[next_lvl[IW-1:0]];

  always_comb begin
    rd_mux = '0;
    if (in_saddr)      rd_mux = slot_addr[idx];
    else if (in_sctrl) rd_mux = DW'(slot_ctrl[idx]);
    else if (is_def)   rd_mux = def_addr;
    else if (is_ack)   rd_mux = ack_addr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(pend_i & cur_mask);
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned ABW   = 12,
  localparam int unsigned LW   = $clog2(NSLOT + 2),
  localparam int unsigned IDLE = NSLOT + 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic [ABW-1:0]  addr_i,
  input logic [NSRC-1:0] pend_i,
  input logic            irq_o,
  input logic [LW-1:0]   lvl_i
);
  logic acc_ack;
  assign acc_ack = req_i && (32'(addr_i) == vic_pkg::OFS_ACK);

  assert_lvl_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i <= LW'(IDLE));

  assert_ack_no_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ack && !we_i |=> lvl_i <= $past(lvl_i));

  assert_ret_lowers_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ack && we_i && (lvl_i != LW'(IDLE)) |=> lvl_i > $past(lvl_i));

  assert_idle_ret_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ack && we_i && (lvl_i == LW'(IDLE)) |=> lvl_i == LW'(IDLE));

  assert_lvl_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_ack |=> $stable(lvl_i));

  assert_idle_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i == LW'(IDLE) |-> irq_o == (|pend_i));

  assert_top_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i == '0 |-> !irq_o);
endmodule

bind nest_vic vic_chk #(.NSRC(NSRC), .NSLOT(NSLOT), .ABW(ABW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .pend_i (pend_i),
  .irq_o  (irq_o),
  .lvl_i  (lvl_q)
);

// File: tb/nest_vic_test.sv
module nest_vic_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [31:0] raw_i = '0, pend_i = '0;
  logic        irq_o;

  int total = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_addr [16];
  logic [7:0]  m_ctrl [16];
  logic [31:0] m_def;
  int          m_lvl;
  int          m_save [17];

  always #10 clk = ~clk;

  nest_vic uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .raw_i(raw_i), .pend_i(pend_i), .irq_o(irq_o)
  );

  function automatic int src_of(int k);
    return (5 * k + 3) % 32;
  endfunction

  function automatic logic [31:0] m_mask(int l);
    logic [31:0] r = '0;
    if (l >= 17) return '1;
    for (int k = 0; k < l && k < 16; k++)
      if (m_ctrl[k][5]) r[m_ctrl[k][4:0]] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = 12'(a); wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
    if (a >= 'h100 && a < 'h140) m_addr[(a - 'h100) / 4] = d;
    else if (a >= 'h200 && a < 'h240) m_ctrl[(a - 'h200) / 4] = d[7:0];
    else if (a == 'h34) m_def = d;
    else if (a == 'h30 && m_lvl < 17) m_lvl = m_save[m_lvl];
  endtask

  task automatic bus_rd(int a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = 12'(a);
    @(negedge clk);
    req_i = 0;
    d = rdata_o;
  endtask

  task automatic ack(string tag);
    int i;
    logic [31:0] exp, got;
    for (i = 0; i < m_lvl; i++)
      if ((raw_i & m_mask(i + 1)) != 0) break;
    if (i == 17) exp = m_def;
    else begin
      if (i < m_lvl) begin m_save[i] = m_lvl; m_lvl = i; end
      exp = (m_lvl >= 16) ? m_def : m_addr[m_lvl];
    end
    bus_rd('h30, got);
    chk(tag, got, exp);
  endtask

  task automatic irq_sweep(string tag);
    logic [31:0] keep = pend_i;
    for (int s = -1; s < 32; s++) begin
      @(negedge clk);
      pend_i = (s < 0) ? 32'h0 : (32'h1 << s);
      #1 chk(tag, 32'(irq_o), 32'(|(pend_i & m_mask(m_lvl))));
    end
    pend_i = keep;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 16; k++) begin m_addr[k] = '0; m_ctrl[k] = '0; end
    for (int l = 0; l < 17; l++) m_save[l] = 17;
    m_def = '0; m_lvl = 17;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: reset values and idle level
    for (int k = 0; k < 16; k++) begin
      bus_rd('h100 + 4 * k, d); chk("R1 slot addr", d, 0);
      bus_rd('h200 + 4 * k, d); chk("R1 slot ctrl", d, 0);
    end
    bus_rd('h34, d); chk("R1 default", d, 0);
    irq_sweep("R1 idle irq");

    // R9: program and read back; slots 5 and 11 left disabled (R2)
    for (int k = 0; k < 16; k++) begin
      bus_wr('h100 + 4 * k, 32'h1000_0000 + 32'(k) * 32'h40 + 32'(k));
      bus_wr('h200 + 4 * k, ((k == 5 || k == 11) ? 32'h0 : 32'h20) | 32'(src_of(k)));
    end
    bus_wr('h34, 32'hDEF0_0016);
    for (int k = 0; k < 16; k++) begin
      bus_rd('h100 + 4 * k, d); chk("R9 addr readback", d, m_addr[k]);
      bus_rd('h200 + 4 * k, d); chk("R9 ctrl readback", d, 32'(m_ctrl[k]));
    end
    bus_rd('h34, d); chk("R9 default readback", d, m_def);
    irq_sweep("R3 idle after program");

    // R4/R5: every single line acknowledged from idle, then returned
    for (int s = 0; s < 32; s++) begin
      raw_i = 32'h1 << s; pend_i = raw_i;
      ack("R4 R5 single line");
      #1 chk("R3 irq after ack", 32'(irq_o), 32'(|(pend_i & m_mask(m_lvl))));
      bus_wr('h30, 32'(s) * 32'h0101_0101);
      #1 chk("R7 irq after return", 32'(irq_o), 32'(|(pend_i & m_mask(m_lvl))));
      chk("R7 back to idle", 32'(m_lvl), 17);
    end

    // R8 nesting, R6 no-change acknowledge
    raw_i = 32'h1 << src_of(9); pend_i = raw_i;
    ack("R8 enter 9");       irq_sweep("R8 level 9");
    raw_i |= 32'h1 << src_of(4);
    ack("R8 enter 4");       irq_sweep("R8 level 4");
    ack("R6 stay 4");        chk("R6 level", 32'(m_lvl), 4);
    raw_i |= 32'h1 << src_of(0);
    ack("R8 enter 0");       irq_sweep("R8 level 0");
    ack("R6 stay 0");
    bus_wr('h30, 32'hFFFF_FFFF); irq_sweep("R8 unwind to 4");
    bus_wr('h30, 32'h0);         irq_sweep("R8 unwind to 9");
    bus_wr('h30, 32'h1234_5678); irq_sweep("R8 unwind to idle");
    chk("R8 idle", 32'(m_lvl), 17);

    // R5 empty acknowledge, R7 return while idle
    raw_i = '0; pend_i = '0;
    ack("R5 empty ack default");
    bus_wr('h30, 32'hA5A5_A5A5);
    irq_sweep("R7 idle return no effect");

    // R2 disabled slot, R10 mask update timing
    raw_i = 32'h1 << src_of(5); pend_i = raw_i;
    ack("R2 disabled slot goes default");
    chk("R2 level 16", 32'(m_lvl), 16);
    #1 chk("R2 line not masked", 32'(irq_o), 0);
    bus_wr('h200 + 4 * 5, 32'h20 | 32'(src_of(5)));
    #1 chk("R10 not yet", 32'(irq_o), 0);
    @(negedge clk);
    #1 chk("R10 after one cycle", 32'(irq_o), 1);
    ack("R2 enabled slot 5");
    chk("R2 level 5", 32'(m_lvl), 5);
    bus_wr('h30, 0); bus_wr('h30, 0);
    irq_sweep("R7 back idle");

    // R3 acknowledge follows raw only
    raw_i = 32'h1 << src_of(3); pend_i = '0;
    ack("R3 raw drives ack");
    #1 chk("R3 gated low irq low", 32'(irq_o), 0);
    bus_wr('h30, 0);
    chk("R3 idle", 32'(m_lvl), 17);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule